// File: doc/BRIEF.md
# Remote Terminal Subaddress Buffer Manager

This block sits between the protocol decoder of a serial-bus remote terminal and a shared, word-addressed RAM. When the decoder hands it a validated command, the block reads two words from the active lookup table: the subaddress control word and the data block pointer for that subaddress and direction. From these it derives the RAM word address of every data word in the message. Three buffering schemes are available: a fixed single block, a ping-pong pair of blocks, or a circular buffer with a programmable size.

When the decoder signals the end of the message, the block writes the updated pointer back into the lookup table and pulses its interrupt outputs, provided the message ended cleanly. Two lookup table areas exist, and a level input selects the active one for each command. A second level input decides whether broadcast receive data uses its own pointer section or shares the receive pointers.

The decoder presents one data word at a time. It reads `dat_addr` while `dat_rdy` is high and pulses `dat_adv` to consume that address.

Top module: `rtsa_bufmgr`

## Requirements
- R1: The control word of subaddress `sa` is read from RAM word `base + 0x60 + sa`. `base` is 0x0140 when `area_sel` is 0 and 0x01C0 when it is 1, and `area_sel` is sampled on the edge that accepts the command.
- R2: The pointer is read from `base + sec + sa`. `sec` is 0x20 for transmit, 0x40 for a broadcast receive while `bcst_sep_en` is 1, and 0x00 for any other receive. A broadcast received while `bcst_sep_en` is 0 also takes the receive fields of the control word.
- R3: A command is accepted on a rising edge where `cmd_vld` is 1 and the block is idle. The cycle after that edge reads the control word and the next cycle reads the pointer; RAM read data returns one cycle after a read. `dat_rdy` is high from the third rising edge after acceptance, and no cycle both reads and writes RAM.
- R4: Single mode: data word i goes to `ptr + i`, and the pointer is never written back.
- R5: Double-buffered mode: data word i goes to `{ptr[15:6], ~ptr[5], i[4:0]}`. A clean end writes back `ptr ^ 0x0020`.
- R6: Circular mode with size code N: the buffer holds 2^(N+7) words and is aligned to its size. With `off = ptr mod size`, word i goes to `base_c + (off+i) mod size`. A clean end after n words writes `base_c` if `off+n >= size` (a rollover), else `base_c + off + n`.
- R7: Control word fields for receive are: mode in bits 1:0 (0 single, 1 double, 2 circular, 3 treated as single), size code in bits 4:2, message interrupt enable in bit 5, and rollover interrupt enable in bit 6. For a separated broadcast, the mode is in bits 14:13 with the same encoding, the message interrupt enable is in bit 15, and the size code and rollover enable are shared with receive.
- R8: For transmit, bit 7 alone selects the mode (0 single, 1 circular). The size code is in bits 10:8, the message interrupt enable in bit 11 and the rollover enable in bit 12. Transmit never uses the double-buffered mode.
- R9: If `msg_err` is 1 together with `msg_end`, there is no pointer write-back and no interrupt.
- R10: On a clean end, the cycle after the `msg_end` edge holds the write-back and one-cycle pulses. `irq_msg` pulses if its enable is set, and `irq_roll` pulses if a rollover occurred and its enable is set. `irq_sa` carries the subaddress.
- R11: A word count of 0 means 32 words. Once that many words have been consumed, `dat_rdy` falls and further `dat_adv` pulses are ignored.
- R12: `cmd_vld` is ignored while a message is in progress.
- R13: After reset the block is idle: no RAM read or write, `dat_rdy` low, and both interrupts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| area_sel | input | 1 | Active lookup table area (0 or 1) |
| bcst_sep_en | input | 1 | Route broadcast receive data through the broadcast pointers |
| cmd_vld | input | 1 | Validated command strobe |
| cmd_tx | input | 1 | Transmit (1) or receive (0) |
| cmd_bcst | input | 1 | Command was broadcast |
| cmd_sa | input | 5 | Subaddress |
| cmd_wc | input | 5 | Word count, 0 means 32 |
| dat_adv | input | 1 | Current data word consumed |
| msg_end | input | 1 | Message finished |
| msg_err | input | 1 | Message finished with an error |
| dat_rdy | output | 1 | `dat_addr` is valid |
| dat_addr | output | 16 | RAM address of the current data word |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after `ram_rd` |
| irq_msg | output | 1 | End-of-message interrupt pulse |
| irq_roll | output | 1 | Circular rollover interrupt pulse |
| irq_sa | output | 5 | Subaddress that raised the interrupt |

## Verification
Every result has a fixed cycle:
- The control word read appears one cycle after the accepting edge, and the pointer read one cycle after that.
- `dat_rdy` rises three edges after acceptance.
- Each data address is valid in the same cycle as the `dat_adv` that consumes it.
- Write-back and interrupts fall in the single cycle after the `msg_end` edge.

The driver changes inputs 2 ns after a rising edge and makes its timing checks 4 ns after the edge. The scoreboard monitor samples on the falling edge. A write or interrupt seen at any other time, or one missing from its cycle, is reported as a failure.

// File: rtl/rtsa_pkg.sv
package rtsa_pkg;

    localparam int ADDR_W        = 16;
    localparam int DW            = 16;
    localparam int SA_W          = 5;
    localparam int WC_W          = 5;
    localparam int MSG_MAX       = 32;
    localparam int IDX_W         = $clog2(MSG_MAX) + 1;
    localparam int BLK_LOG2      = $clog2(MSG_MAX);
    localparam int CIRC_MIN_LOG2 = 7;
    localparam int SIZE_W        = 3;
    localparam int SHIFT_W       = 4;

    typedef enum logic [1:0] {
        BUF_SINGLE = 2'd0,
        BUF_DOUBLE = 2'd1,
        BUF_CIRC   = 2'd2
    } buf_mode_e;

    // Section order inside one lookup area; the offset is {sec, sa}.
    typedef enum logic [1:0] {
        SEC_RX = 2'd0,
        SEC_TX = 2'd1,
        SEC_BC = 2'd2,
        SEC_CW = 2'd3
    } lut_sec_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CW,
        ST_RD_PTR,
        ST_CAP,
        ST_XFER,
        ST_WB
    } seq_st_e;

    typedef struct packed {
        buf_mode_e         mode;
        logic [SIZE_W-1:0] size;
        logic              irq_msg_en;
        logic              irq_roll_en;
    } sa_cfg_t;

    typedef struct packed {
        logic              area;
        lut_sec_e          sec;
        logic [SA_W-1:0]   sa;
        logic [IDX_W-1:0]  nwords;
    } cmd_t;

    function automatic buf_mode_e mode_of(input logic [1:0] code);
        return (code == 2'd3) ? BUF_SINGLE : buf_mode_e'(code);
    endfunction

    function automatic sa_cfg_t decode_cw(input logic [DW-1:0] cw, input lut_sec_e sec);
        sa_cfg_t c;
        c = '0;
        case (sec)
            SEC_TX: begin
                c.mode        = cw[7] ? BUF_CIRC : BUF_SINGLE;
                c.size        = cw[10:8];
                c.irq_msg_en  = cw[11];
                c.irq_roll_en = cw[12];
            end
            SEC_BC: begin
                c.mode        = mode_of(cw[14:13]);
                c.size        = cw[4:2];
                c.irq_msg_en  = cw[15];
                c.irq_roll_en = cw[6];
            end
            default: begin
                c.mode        = mode_of(cw[1:0]);
                c.size        = cw[4:2];
                c.irq_msg_en  = cw[5];
                c.irq_roll_en = cw[6];
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rtsa_lut_addr.sv
module rtsa_lut_addr
    import rtsa_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_A = 16'h0140,
    parameter logic [ADDR_W-1:0] BASE_B = 16'h01C0
) (
    input  logic              area,
    input  lut_sec_e          sec,
    input  logic [SA_W-1:0]   sa,
    output logic [ADDR_W-1:0] addr
);

    localparam int OFS_W = SA_W + 2;

    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs  = {sec, sa};
        addr = (area ? BASE_B : BASE_A) + ADDR_W'(ofs);
    end

endmodule

// File: rtl/rtsa_addr_gen.sv
module rtsa_addr_gen
    import rtsa_pkg::*;
(
    input  sa_cfg_t           cfg,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] dat_addr,
    output logic [ADDR_W-1:0] nxt_ptr,
    output logic              wb_en,
    output logic              roll
);

    logic [ADDR_W-1:0]  mask;
    logic [ADDR_W-1:0]  cbase;
    logic [ADDR_W-1:0]  off;
    logic [ADDR_W:0]    sum;
    logic [SHIFT_W-1:0] shamt;

    always_comb begin
        shamt    = SHIFT_W'(cfg.size) + SHIFT_W'(CIRC_MIN_LOG2);
        mask     = (ADDR_W'(1) << shamt) - ADDR_W'(1);
        cbase    = ptr & ~mask;
        off      = ptr & mask;
        sum      = {1'b0, off} + (ADDR_W+1)'(idx);
        dat_addr = ptr + ADDR_W'(idx);
        nxt_ptr  = ptr;
        wb_en    = 1'b0;
        roll     = 1'b0;
        case (cfg.mode)
            BUF_DOUBLE: begin
                dat_addr = {ptr[ADDR_W-1:BLK_LOG2+1], ~ptr[BLK_LOG2], idx[BLK_LOG2-1:0]};
                nxt_ptr  = ptr ^ (ADDR_W'(1) << BLK_LOG2);
                wb_en    = 1'b1;
            end
            BUF_CIRC: begin
                roll     = sum > {1'b0, mask};
                dat_addr = cbase | (sum[ADDR_W-1:0] & mask);
                nxt_ptr  = roll ? cbase : (cbase | sum[ADDR_W-1:0]);
                wb_en    = 1'b1;
            end
            default: begin
                wb_en    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rtsa_seq.sv
module rtsa_seq
    import rtsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              area_sel,
    input  logic              bcst_sep_en,
    input  logic              cmd_vld,
    input  logic              cmd_tx,
    input  logic              cmd_bcst,
    input  logic [SA_W-1:0]   cmd_sa,
    input  logic [WC_W-1:0]   cmd_wc,
    input  logic              dat_adv,
    input  logic              msg_end,
    input  logic              msg_err,
    input  logic [DW-1:0]     ram_rdata,
    input  logic [ADDR_W-1:0] cw_addr,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic [ADDR_W-1:0] gen_addr,
    input  logic [ADDR_W-1:0] gen_nxt,
    input  logic              gen_wb,
    input  logic              gen_roll,
    output cmd_t              cur,
    output sa_cfg_t           cfg,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [IDX_W-1:0]  idx,
    output logic              dat_rdy,
    output logic [ADDR_W-1:0] dat_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic              irq_msg,
    output logic              irq_roll,
    output logic [SA_W-1:0]   irq_sa
);

    seq_st_e       st;
    logic [DW-1:0] cw_q;
    logic          err_q;
    logic          accept;
    lut_sec_e      sec_in;

    always_comb begin
        accept = (st == ST_IDLE) && cmd_vld;
        if (cmd_tx)
            sec_in = SEC_TX;
        else if (cmd_bcst && bcst_sep_en)
            sec_in = SEC_BC;
        else
            sec_in = SEC_RX;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cur   <= '0;
            cw_q  <= '0;
            ptr_q <= '0;
            idx   <= '0;
            err_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cur.area   <= area_sel;
                        cur.sec    <= sec_in;
                        cur.sa     <= cmd_sa;
                        cur.nwords <= (cmd_wc == '0) ? IDX_W'(MSG_MAX) : IDX_W'(cmd_wc);
                        idx        <= '0;
                        st         <= ST_RD_CW;
                    end
                end
                ST_RD_CW:  st <= ST_RD_PTR;
                ST_RD_PTR: begin
                    cw_q <= ram_rdata;
                    st   <= ST_CAP;
                end
                ST_CAP: begin
                    ptr_q <= ram_rdata;
                    st    <= ST_XFER;
                end
                ST_XFER: begin
                    if (dat_adv && (idx < cur.nwords))
                        idx <= idx + IDX_W'(1);
                    if (msg_end) begin
                        err_q <= msg_err;
                        st    <= ST_WB;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cfg       = decode_cw(cw_q, cur.sec);
        ram_rd    = (st == ST_RD_CW) || (st == ST_RD_PTR);
        ram_addr  = (st == ST_RD_CW) ? cw_addr : ptr_addr;
        ram_wr    = (st == ST_WB) && gen_wb && !err_q;
        ram_wdata = gen_nxt;
        dat_rdy   = (st == ST_XFER) && (idx < cur.nwords);
        dat_addr  = gen_addr;
        irq_msg   = (st == ST_WB) && !err_q && cfg.irq_msg_en;
        irq_roll  = (st == ST_WB) && !err_q && gen_roll && cfg.irq_roll_en;
        irq_sa    = cur.sa;
    end

    AST_CW_FETCH_NEXT: assert property (@(posedge clk) disable iff (rst) accept |=> (ram_rd && ram_addr == $past(area_sel ? 16'h0 : 16'h0) + cw_addr)); // R1
    AST_RDY_DEADLINE: assert property (@(posedge clk) disable iff (rst) ($past(ram_rd, 2) && $past(ram_rd, 3)) |-> dat_rdy); // R3
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(ram_rd && ram_wr)); // R3
    AST_NO_WR_ON_ERR: assert property (@(posedge clk) disable iff (rst) ram_wr |-> $past(msg_end && !msg_err)); // R9
    AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (rst) (irq_msg || irq_roll) |-> $past(msg_end && !msg_err)); // R10
    AST_RDY_STOPS: assert property (@(posedge clk) disable iff (rst) (dat_rdy && dat_adv && !msg_end && (idx + IDX_W'(1) == cur.nwords)) |=> !dat_rdy); // R11
    AST_BUSY_NO_FETCH: assert property (@(posedge clk) disable iff (rst) (dat_rdy && !msg_end) |=> !ram_rd); // R12

endmodule

// File: rtl/rtsa_bufmgr.sv
module rtsa_bufmgr
    import rtsa_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LUT_A_BASE = 16'h0140,
    parameter logic [ADDR_W-1:0] LUT_B_BASE = 16'h01C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              area_sel,
    input  logic              bcst_sep_en,
    input  logic              cmd_vld,
    input  logic              cmd_tx,
    input  logic              cmd_bcst,
    input  logic [SA_W-1:0]   cmd_sa,
    input  logic [WC_W-1:0]   cmd_wc,
    input  logic              dat_adv,
    input  logic              msg_end,
    input  logic              msg_err,
    output logic              dat_rdy,
    output logic [ADDR_W-1:0] dat_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic              irq_msg,
    output logic              irq_roll,
    output logic [SA_W-1:0]   irq_sa
);

    localparam int N_LOOKUP = 2;

    cmd_t              cur;
    sa_cfg_t           cfg;
    logic [ADDR_W-1:0] ptr_q;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] gen_addr;
    logic [ADDR_W-1:0] gen_nxt;
    logic              gen_wb;
    logic              gen_roll;
    logic [ADDR_W-1:0] lk_addr [N_LOOKUP];

    // Lookup 0 addresses the control word, lookup 1 the data pointer.
    for (genvar g = 0; g < N_LOOKUP; g++) begin : g_lookup
        lut_sec_e sec_g;
        assign sec_g = (g == 0) ? SEC_CW : cur.sec;
        rtsa_lut_addr #(
            .BASE_A (LUT_A_BASE),
            .BASE_B (LUT_B_BASE)
        ) u_lut (
            .area (cur.area),
            .sec  (sec_g),
            .sa   (cur.sa),
            .addr (lk_addr[g])
        );
    end

    rtsa_addr_gen u_gen (
        .cfg      (cfg),
        .ptr      (ptr_q),
        .idx      (idx),
        .dat_addr (gen_addr),
        .nxt_ptr  (gen_nxt),
        .wb_en    (gen_wb),
        .roll     (gen_roll)
    );

    rtsa_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .area_sel    (area_sel),
        .bcst_sep_en (bcst_sep_en),
        .cmd_vld     (cmd_vld),
        .cmd_tx      (cmd_tx),
        .cmd_bcst    (cmd_bcst),
        .cmd_sa      (cmd_sa),
        .cmd_wc      (cmd_wc),
        .dat_adv     (dat_adv),
        .msg_end     (msg_end),
        .msg_err     (msg_err),
        .ram_rdata   (ram_rdata),
        .cw_addr     (lk_addr[0]),
        .ptr_addr    (lk_addr[1]),
        .gen_addr    (gen_addr),
        .gen_nxt     (gen_nxt),
        .gen_wb      (gen_wb),
        .gen_roll    (gen_roll),
        .cur         (cur),
        .cfg         (cfg),
        .ptr_q       (ptr_q),
        .idx         (idx),
        .dat_rdy     (dat_rdy),
        .dat_addr    (dat_addr),
        .ram_rd      (ram_rd),
        .ram_wr      (ram_wr),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .irq_msg     (irq_msg),
        .irq_roll    (irq_roll),
        .irq_sa      (irq_sa)
    );

    AST_CW_IN_AREA: assert property (@(posedge clk) disable iff (rst) (ram_rd && !$past(ram_rd)) |-> (ram_addr >= LUT_A_BASE + 16'h0060 && ram_addr < LUT_B_BASE + 16'h0080)); // R1

endmodule

// File: tb/sim_rtsa_bufmgr.sv
module sim_rtsa_bufmgr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        area_sel = 1'b0, bcst_sep_en = 1'b0;
    logic        cmd_vld = 1'b0, cmd_tx = 1'b0, cmd_bcst = 1'b0;
    logic [4:0]  cmd_sa = '0, cmd_wc = '0;
    logic        dat_adv = 1'b0, msg_end = 1'b0, msg_err = 1'b0;
    logic        dat_rdy, ram_rd, ram_wr, irq_msg, irq_roll;
    logic [15:0] dat_addr, ram_addr, ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic [4:0]  irq_sa;

    always #5 clk = ~clk;

    rtsa_bufmgr u0 (
        .clk(clk), .rst(rst), .area_sel(area_sel), .bcst_sep_en(bcst_sep_en),
        .cmd_vld(cmd_vld), .cmd_tx(cmd_tx), .cmd_bcst(cmd_bcst), .cmd_sa(cmd_sa),
        .cmd_wc(cmd_wc), .dat_adv(dat_adv), .msg_end(msg_end), .msg_err(msg_err),
        .dat_rdy(dat_rdy), .dat_addr(dat_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .irq_msg(irq_msg), .irq_roll(irq_roll), .irq_sa(irq_sa)
    );

    logic [15:0] mem [0:1023];

    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= mem[ram_addr[9:0]];
        if (ram_wr) mem[ram_addr[9:0]] <= ram_wdata;
    end

    typedef struct packed { logic [1:0] mode; logic [15:0] addr; } exp_addr_t;
    typedef struct packed { logic [1:0] mode; logic [15:0] addr; logic [15:0] data; } exp_wr_t;
    typedef struct packed { logic m; logic r; logic [4:0] sa; } exp_irq_t;

    exp_addr_t aq[$];
    exp_wr_t   wq[$];
    exp_irq_t  iq[$];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        if (m == 2'd1) return "R5";
        if (m == 2'd2) return "R6";
        return "R4";
    endfunction

    // Scoreboard monitor, samples on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (dat_rdy && dat_adv) begin
                if (aq.size() == 0) chk(1'b0, "R11 extra data word", {16'h0, dat_addr}, 32'h0);
                else begin
                    exp_addr_t ea;
                    ea = aq.pop_front();
                    chk(dat_addr == ea.addr, mode_tag(ea.mode), {16'h0, dat_addr}, {16'h0, ea.addr});
                end
            end
            if (ram_wr) begin
                if (wq.size() == 0) chk(1'b0, "R9 R4 unexpected write-back", {ram_addr, ram_wdata}, 32'h0);
                else begin
                    exp_wr_t ew;
                    ew = wq.pop_front();
                    chk({ram_addr, ram_wdata} == {ew.addr, ew.data}, mode_tag(ew.mode),
                        {ram_addr, ram_wdata}, {ew.addr, ew.data});
                end
            end
            if (irq_msg || irq_roll) begin
                if (iq.size() == 0) chk(1'b0, "R9 R10 unexpected interrupt", {25'h0, irq_msg, irq_roll, irq_sa}, 32'h0);
                else begin
                    exp_irq_t ei;
                    ei = iq.pop_front();
                    chk({irq_msg, irq_roll, irq_sa} == {ei.m, ei.r, ei.sa}, "R10",
                        {25'h0, irq_msg, irq_roll, irq_sa}, {25'h0, ei.m, ei.r, ei.sa});
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Driver: computes expectations from the requirements, then drives one message.
    task automatic run_msg(input bit area, input bit sep, input bit tx, input bit bc,
                           input logic [4:0] sa, input logic [4:0] wc, input int nadv,
                           input bit err, input bit poke);
        logic [15:0] base, cwa, pa, cw, ptr, cbase, nw16;
        logic [1:0]  mode;
        logic [2:0]  sz;
        bit          men, ren, roll;
        int          size, off, nw, ndone;
        base = area ? 16'h01C0 : 16'h0140;
        cwa  = base + 16'h0060 + 16'(sa);                                  // R1
        pa   = base + (tx ? 16'h0020 : (bc && sep) ? 16'h0040 : 16'h0000) + 16'(sa); // R2
        cw   = mem[cwa[9:0]];
        ptr  = mem[pa[9:0]];
        if (tx) begin                                                      // R8
            mode = cw[7] ? 2'd2 : 2'd0; sz = cw[10:8]; men = cw[11]; ren = cw[12];
        end else if (bc && sep) begin                                      // R7
            mode = (cw[14:13] == 2'd3) ? 2'd0 : cw[14:13]; sz = cw[4:2]; men = cw[15]; ren = cw[6];
        end else begin
            mode = (cw[1:0] == 2'd3) ? 2'd0 : cw[1:0]; sz = cw[4:2]; men = cw[5]; ren = cw[6];
        end
        nw    = (wc == 0) ? 32 : int'(wc);                                 // R11
        ndone = (nadv < nw) ? nadv : nw;
        size  = 1 << (int'(sz) + 7);
        off   = int'(ptr) % size;
        cbase = ptr - 16'(off);
        roll  = 1'b0;
        for (int i = 0; i < ndone; i++) begin
            exp_addr_t ea;
            ea.mode = mode;
            if (mode == 2'd0) ea.addr = ptr + 16'(i);                       // R4
            else if (mode == 2'd1) ea.addr = (ptr & 16'hFFC0) + (ptr[5] ? 16'h0 : 16'h20) + 16'(i); // R5
            else ea.addr = cbase + 16'((off + i) % size);                  // R6
            aq.push_back(ea);
        end
        if (mode == 2'd2) begin
            roll = (off + ndone) >= size;
            nw16 = roll ? cbase : cbase + 16'(off + ndone);
        end else nw16 = ptr ^ 16'h0020;
        if (!err) begin                                                    // R9
            if (mode != 2'd0) begin
                exp_wr_t ew;
                ew.mode = mode; ew.addr = pa; ew.data = nw16;
                wq.push_back(ew);
            end
            if (men || (roll && ren)) begin
                exp_irq_t ei;
                ei.m = men; ei.r = roll && ren; ei.sa = sa;
                iq.push_back(ei);
            end
        end

        area_sel = area; bcst_sep_en = sep; cmd_tx = tx; cmd_bcst = bc;
        cmd_sa = sa; cmd_wc = wc; cmd_vld = 1'b1;
        step();
        cmd_vld = 1'b0; area_sel = ~area; bcst_sep_en = ~sep;
        #2 chk(ram_rd && ram_addr == cwa, "R1 R3 control word read", {15'h0, ram_rd, ram_addr}, {16'h1, cwa});
        step();
        #2 chk(ram_rd && ram_addr == pa, "R2 R3 pointer read", {15'h0, ram_rd, ram_addr}, {16'h1, pa});
        step();
        #2 chk(!dat_rdy, "R3 ready not early", {31'h0, dat_rdy}, 32'h0);
        step();
        #2 chk(dat_rdy, "R3 ready deadline", {31'h0, dat_rdy}, 32'h1);
        for (int i = 0; i < nadv; i++) begin
            dat_adv = 1'b1;
            if (poke && i == 0) begin
                cmd_vld = 1'b1; cmd_sa = sa + 5'd1;
            end
            step();
            if (poke && i == 0) begin
                cmd_vld = 1'b0;
                #2 chk(!ram_rd, "R12 command ignored while busy", {31'h0, ram_rd}, 32'h0);
            end
        end
        dat_adv = 1'b0;
        if (nadv > nw) begin
            #1 chk(!dat_rdy, "R11 ready falls after word count", {31'h0, dat_rdy}, 32'h0);
        end
        msg_end = 1'b1; msg_err = err;
        step();
        msg_end = 1'b0; msg_err = 1'b0;
        step();
        step();
        chk(aq.size() == 0 && wq.size() == 0 && iq.size() == 0, "R9 R10 all expected events seen",
            aq.size() + wq.size() + iq.size(), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        #2 chk(!ram_rd && !ram_wr && !dat_rdy && !irq_msg && !irq_roll, "R13 reset state",
               {27'h0, ram_rd, ram_wr, dat_rdy, irq_msg, irq_roll}, 32'h0);

        // R4: single, area A, message interrupt
        mem[16'h01A3] = 16'h0020; mem[16'h0143] = 16'h0800;
        run_msg(1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 5'd4, 4, 1'b0, 1'b0);

        // R5: double buffered, area B, twice to see both halves
        mem[16'h0225] = 16'h0021; mem[16'h01C5] = 16'h1040;
        run_msg(1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 5'd3, 3, 1'b0, 1'b0);
        chk(mem[16'h01C5] == 16'h1060, "R5 pointer toggled", {16'h0, mem[16'h01C5]}, 32'h1060);
        run_msg(1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 5'd3, 3, 1'b0, 1'b0);

        // R9: double buffered ending in error
        run_msg(1'b1, 1'b0, 1'b0, 1'b0, 5'd5, 5'd2, 2, 1'b1, 1'b0);
        chk(mem[16'h01C5] == 16'h1040, "R9 pointer unchanged after error", {16'h0, mem[16'h01C5]}, 32'h1040);

        // R6: circular 128 words, rollover with both interrupts
        mem[16'h01A7] = 16'h0062; mem[16'h0147] = 16'h207E;
        run_msg(1'b0, 1'b0, 1'b0, 1'b0, 5'd7, 5'd4, 4, 1'b0, 1'b0);

        // R6: circular 512 words, 32 words, no rollover, no interrupt
        mem[16'h01A8] = 16'h004A; mem[16'h0148] = 16'h4010;
        run_msg(1'b0, 1'b0, 1'b0, 1'b0, 5'd8, 5'd0, 32, 1'b0, 1'b0);

        // R9: circular ending in error
        run_msg(1'b0, 1'b0, 1'b0, 1'b0, 5'd8, 5'd3, 3, 1'b1, 1'b0);

        // R8: transmit circular 256 words across the end
        mem[16'h01A9] = 16'h0980; mem[16'h0169] = 16'h30F0;
        run_msg(1'b0, 1'b0, 1'b1, 1'b0, 5'd9, 5'd20, 20, 1'b0, 1'b0);

        // R8: transmit single although receive fields say circular
        mem[16'h01AA] = 16'h0802; mem[16'h016A] = 16'h5000;
        run_msg(1'b0, 1'b0, 1'b1, 1'b0, 5'd10, 5'd5, 5, 1'b0, 1'b0);

        // R2 R7: broadcast with separation uses broadcast section and fields
        mem[16'h0224] = 16'hA002; mem[16'h0204] = 16'h6000; mem[16'h01C4] = 16'h7000;
        run_msg(1'b1, 1'b1, 1'b0, 1'b1, 5'd4, 5'd2, 2, 1'b0, 1'b0);

        // R2 R7: broadcast without separation uses receive section and fields
        run_msg(1'b1, 1'b0, 1'b0, 1'b1, 5'd4, 5'd2, 2, 1'b0, 1'b0);

        // R11 R12: extra advances ignored, command while busy ignored
        mem[16'h01AC] = 16'h0000; mem[16'h014C] = 16'h0300;
        run_msg(1'b0, 1'b0, 1'b0, 1'b0, 5'd12, 5'd2, 4, 1'b0, 1'b1);

        finish_run();
    end

endmodule